// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the control unit of a small multi-cycle accumulator processor. Every instruction is stepped through a fixed set of phases: a fetch phase that reads the instruction word and decodes it, an optional indirect phase that swaps the address field for the word it points to, an execute phase, and, when interrupts are enabled and a request is waiting, an interrupt phase that pushes the return address and jumps to a fixed service address. A one-hot register of four phase flags records which phase is active. A step counter orders the beats inside each phase, and it restarts at zero whenever the phase changes.

The sequencer owns the program counter, memory address register, memory data register, instruction register, stack pointer and accumulator. It talks to a single-port memory with an asynchronous read path through registered address, write data and separate active-high read and write strobes. Each access takes one beat to present the address and strobe and one beat to capture the data or complete the write. The instruction word is 8 bits wide: a 3-bit opcode in bits 7..5, an indirect flag in bit 4 and a 4-bit address field in bits 3..0.

Top module: `icyc_sequencer`

## Requirements
- R1: Exactly one bit of `phase_o` is set at all times (bit 0 fetch, bit 1 indirect, bit 2 execute, bit 3 interrupt). After reset, fetch is active, PC is 0, SP is the top address (15), the accumulator is 0 and interrupts are disabled.
- R2: Fetch takes three beats: beat 0 drives the PC onto `mem_addr` with `mem_rd` high, beat 1 captures the word into the data register and increments the PC by one, and beat 2 moves the word into the instruction register and decodes it.
- R3: At the end of fetch, the sequencer enters the indirect phase when bit 4 of the fetched word is 1 and the execute phase otherwise.
- R4: The indirect phase reads the word at the address field over two beats. In a third beat it writes the low four bits of that word into the address field, and then it enters execute.
- R5: Opcode 0 (load) reads the memory word at the address into the accumulator. Opcode 2 (add) adds that word to the accumulator modulo 256. Opcode 1 (store) writes the accumulator to the address, with `mem_wr` high for one beat.
- R6: Opcode 3 (jump) loads the address field into the PC. Opcode 4 enables and opcode 5 disables interrupts. Opcode 6 does nothing. All four take a single execute beat.
- R7: The interrupt phase is entered only at the end of an execute phase, and only when `irq` is high and interrupts are enabled as they stand after that instruction. A request at any other time, or while interrupts are disabled, is ignored. Entering the phase clears `int_en`.
- R8: The interrupt phase first decrements SP and sends the new SP to `mem_addr`. It then writes the PC with `mem_wr` high, and finally loads the vector address (default 8) into the PC before fetch resumes.
- R9: Opcode 7 (halt) keeps the sequencer in execute with no strobes and no state change until reset.
- R10: `mem_rd` and `mem_wr` are active high, never high together, and each is high for a single beat per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 4 | Memory address (address register) |
| mem_wdata | output | 8 | Write data (data register) |
| mem_rdata | input | 8 | Read data, valid in the same beat as the address |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| irq | input | 1 | Interrupt request level |
| int_en | output | 1 | Current interrupt-enable flag |
| phase_o | output | 4 | One-hot phase vector |
| acc_o | output | 8 | Accumulator |

## Verification
Address, strobes, phase flags and `int_en` are registered, so each one shows its new value one clock after the rising edge of the beat that computes it. Read data is captured at the rising edge that ends the beat in which the strobe is high, so the accumulator moves one clock after the read strobe is seen. A store or push lands in memory at the edge that ends its write-strobe beat. The bench steps a behavioural model at every rising edge, using the same `irq` level the design sees, and compares all outputs at the following falling edge. As a result every check lands one clock after its cause. Directed checks made after the program has halted confirm the stored value, the pushed return address, the count of indirect phases and a skipped address.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
  localparam int NPH    = 4;
  localparam int PH_FET = 0;
  localparam int PH_IND = 1;
  localparam int PH_EXE = 2;
  localparam int PH_INT = 3;
  localparam int OPW    = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_JUMP  = 3'd3,
    OP_EI    = 3'd4,
    OP_DI    = 3'd5,
    OP_NOP   = 3'd6,
    OP_HALT  = 3'd7
  } opcode_e;
endpackage

// File: rtl/icyc_decode.sv
module icyc_decode
  import icyc_pkg::*;
(
  input  logic [NPH-1:0] phase,
  input  logic [1:0]     step,
  input  opcode_e        op,
  input  logic           ind_bit,
  input  logic           irq,
  input  logic           ien,
  output logic           last,
  output logic [NPH-1:0] nxt,
  output logic           ien_after
);
  logic mem_op;
  assign mem_op = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);

  always_comb begin
    ien_after = ien;
    if (phase[PH_EXE] && op == OP_EI) ien_after = 1'b1;
    if (phase[PH_EXE] && op == OP_DI) ien_after = 1'b0;
  end

  always_comb begin
    last = 1'b0;
    nxt  = '0;
    unique case (1'b1)
      phase[PH_FET]: begin
        last = (step == 2'd2);
        nxt[ind_bit ? PH_IND : PH_EXE] = 1'b1;
      end
      phase[PH_IND]: begin
        last = (step == 2'd2);
        nxt[PH_EXE] = 1'b1;
      end
      phase[PH_EXE]: begin
        last = mem_op ? (step == 2'd1) : (op != OP_HALT);
        nxt[(irq && ien_after) ? PH_INT : PH_FET] = 1'b1;
      end
      phase[PH_INT]: begin
        last = (step == 2'd2);
        nxt[PH_FET] = 1'b1;
      end
      default: begin
        last = 1'b0;
        nxt  = '0;
      end
    endcase
  end
endmodule

// File: rtl/icyc_phase_reg.sv
module icyc_phase_reg
  import icyc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           last,
  input  logic           hold,
  input  logic [NPH-1:0] nxt,
  output logic [NPH-1:0] phase,
  output logic [1:0]     step
);
  localparam logic [NPH-1:0] PH_RESET = NPH'(1) << PH_FET;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_RESET;
      step  <= '0;
    end else if (last) begin
      phase <= nxt;
      step  <= '0;
    end else if (!hold) begin
      step  <= step + 2'd1;
    end
  end

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);
endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
  import icyc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int VEC = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          irq,
  output logic          int_en,
  output logic [NPH-1:0] phase_o,
  output logic [DW-1:0] acc_o
);
  localparam logic [AW-1:0] SP_TOP = {AW{1'b1}};
  localparam logic [AW-1:0] VEC_A  = AW'(VEC);
  localparam int            IND_B  = AW;

  logic [AW-1:0]  pc, mar, sp;
  logic [DW-1:0]  mdr, ir, acc;
  logic           ien, rd, wr, halted;
  logic [NPH-1:0] phase, nxt;
  logic [1:0]     step;
  logic           last, ien_after;
  opcode_e        op;
  logic [AW-1:0]  fld;

  assign op  = opcode_e'(ir[DW-1 -: OPW]);
  assign fld = ir[AW-1:0];

  icyc_decode u_dec (
    .phase(phase), .step(step), .op(op), .ind_bit(mdr[IND_B]),
    .irq(irq), .ien(ien), .last(last), .nxt(nxt), .ien_after(ien_after)
  );

  icyc_phase_reg u_ph (
    .clk(clk), .rst(rst), .last(last), .hold(halted),
    .nxt(nxt), .phase(phase), .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; sp <= SP_TOP;
      mdr <= '0; ir <= '0; acc <= '0;
      ien <= 1'b0; rd <= 1'b0; wr <= 1'b0; halted <= 1'b0;
    end else begin
      rd <= 1'b0;
      wr <= 1'b0;
      if (!halted) begin
        if (phase[PH_FET]) begin
          case (step)
            2'd0: begin mar <= pc; rd <= 1'b1; end
            2'd1: begin mdr <= mem_rdata; pc <= pc + 1'b1; end
            2'd2: ir <= mdr;
            default: ;
          endcase
        end
        if (phase[PH_IND]) begin
          case (step)
            2'd0: begin mar <= fld; rd <= 1'b1; end
            2'd1: mdr <= mem_rdata;
            2'd2: ir[AW-1:0] <= mdr[AW-1:0];
            default: ;
          endcase
        end
        if (phase[PH_EXE]) begin
          case (op)
            OP_LOAD, OP_ADD: begin
              if (step == 2'd0) begin
                mar <= fld;
                rd  <= 1'b1;
              end else begin
                mdr <= mem_rdata;
                acc <= (op == OP_LOAD) ? mem_rdata : acc + mem_rdata;
              end
            end
            OP_STORE: if (step == 2'd0) begin
              mar <= fld;
              mdr <= acc;
              wr  <= 1'b1;
            end
            OP_JUMP: pc <= fld;
            OP_HALT: halted <= 1'b1;
            default: ;
          endcase
          if (last) ien <= nxt[PH_INT] ? 1'b0 : ien_after;
        end
        if (phase[PH_INT]) begin
          case (step)
            2'd0: begin sp <= sp - 1'b1; mar <= sp - 1'b1; end
            2'd1: begin mdr <= {{(DW-AW){1'b0}}, pc}; wr <= 1'b1; end
            2'd2: pc <= VEC_A;
            default: ;
          endcase
        end
      end
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = rd;
  assign mem_wr    = wr;
  assign int_en    = ien;
  assign phase_o   = phase;
  assign acc_o     = acc;

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);
  assert_int_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(phase[PH_INT]) |-> $past(irq) && $past(phase[PH_EXE]));
  assert_int_clears_en_R7: assert property (@(posedge clk) disable iff (rst)
    phase[PH_INT] |-> !ien);
  assert_push_data_R8: assert property (@(posedge clk) disable iff (rst)
    (phase[PH_INT] && mem_wr) |-> (mem_wdata[AW-1:0] == pc) && (mem_addr == sp));
  assert_ind_only_flagged_R4: assert property (@(posedge clk) disable iff (rst)
    (phase[PH_IND] && step == 2'd2) |-> ir[IND_B]);
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && phase[PH_EXE] && !mem_rd && !mem_wr);
endmodule

// File: tb/sim_icyc_sequencer.sv
module sim_icyc_sequencer;
  localparam int DW = 8, AW = 4, VEC = 8, DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_rd, mem_wr, int_en;
  logic [3:0] phase_o;
  logic [DW-1:0] acc_o;

  always #10 clk = ~clk;

  icyc_sequencer #(.DW(DW), .AW(AW), .VEC(VEC)) u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq),
    .int_en(int_en), .phase_o(phase_o), .acc_o(acc_o)
  );

  logic [DW-1:0] mem [DEPTH];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_en = 0;
  int ind_entries = 0, fetch7 = 0;
  logic [3:0] prev_ph = 4'b0001;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mmem [DEPTH];
  int m_ph, m_st, m_pc, m_mar, m_mdr, m_ir, m_sp, m_acc, m_ien, m_rd, m_wr, m_halt;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_st = 0; m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0;
      m_sp = 15; m_acc = 0; m_ien = 0; m_rd = 0; m_wr = 0; m_halt = 0;
    end else begin
      int rdv, nrd, nwr, fin, nph, op, a, ien_a;
      cyc++;
      if (m_wr) mmem[m_mar] = m_mdr;
      rdv = mmem[m_mar];
      nrd = 0; nwr = 0; fin = 0; nph = 0;
      if (!m_halt) begin
        if (m_ph == 0) begin
          if (m_st == 0) begin m_mar = m_pc; nrd = 1; end
          else if (m_st == 1) begin m_mdr = rdv; m_pc = (m_pc + 1) % 16; end
          else begin m_ir = m_mdr; fin = 1; nph = ((m_mdr >> 4) & 1) ? 1 : 2; end
        end else if (m_ph == 1) begin
          if (m_st == 0) begin m_mar = m_ir % 16; nrd = 1; end
          else if (m_st == 1) m_mdr = rdv;
          else begin m_ir = (m_ir & 240) | (m_mdr % 16); fin = 1; nph = 2; end
        end else if (m_ph == 2) begin
          op = m_ir >> 5; a = m_ir % 16; ien_a = m_ien;
          if (op == 0 || op == 2) begin
            if (m_st == 0) begin m_mar = a; nrd = 1; end
            else begin
              m_mdr = rdv;
              m_acc = (op == 0) ? rdv : (m_acc + rdv) % 256;
              fin = 1;
            end
          end else if (op == 1) begin
            if (m_st == 0) begin m_mar = a; m_mdr = m_acc; nwr = 1; end
            else fin = 1;
          end else if (op == 3) begin m_pc = a; fin = 1; end
          else if (op == 4) begin ien_a = 1; fin = 1; end
          else if (op == 5) begin ien_a = 0; fin = 1; end
          else if (op == 6) fin = 1;
          else m_halt = 1;
          if (fin) begin
            if (irq && ien_a) begin nph = 3; m_ien = 0; end
            else begin nph = 0; m_ien = ien_a; end
          end
        end else begin
          if (m_st == 0) begin m_sp = (m_sp + 15) % 16; m_mar = m_sp; end
          else if (m_st == 1) begin m_mdr = m_pc; nwr = 1; end
          else begin m_pc = VEC; fin = 1; nph = 0; end
        end
      end
      m_rd = nrd; m_wr = nwr;
      if (fin) begin m_ph = nph; m_st = 0; end
      else if (!m_halt) m_st++;
    end
  end

  // every-cycle comparison, one clock after the causing edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1", "phase_o", phase_o, 1 << m_ph);
      chk("R2", "mem_addr", mem_addr, m_mar);
      chk("R10", "mem_rd", mem_rd, m_rd);
      chk("R10", "mem_wr", mem_wr, m_wr);
      chk("R5", "acc_o", acc_o, m_acc);
      chk("R7", "int_en", int_en, m_ien);
      if (mem_wr) chk("R8", "mem_wdata", mem_wdata, m_mdr);
      if (phase_o == 4'b0010 && prev_ph != 4'b0010) ind_entries++;
      if (phase_o[0] && mem_rd && mem_addr == 4'd7) fetch7++;
      prev_ph = phase_o;
    end
  end

  // irq: early burst while disabled, then held high from mid-program on
  always @(negedge clk) irq <= (cyc >= 2 && cyc < 10) || (cyc >= 14);

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 120);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] prog [DEPTH];
    prog = '{8'h0B, 8'h5C, 8'h2F, 8'h80, 8'hC0, 8'hA0, 8'h6A, 8'hE0,
             8'h4B, 8'h7E, 8'hE0, 8'h05, 8'h0D, 8'h03, 8'h00, 8'h00};
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = prog[i];
      mmem[i] = prog[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset phase_o", phase_o, 1);
    chk("R1", "reset acc_o", acc_o, 0);
    chk("R1", "reset int_en", int_en, 0);
    chk("R10", "reset strobes", {mem_rd, mem_wr}, 0);
    rst = 1'b0;
    cmp_en = 1;
    repeat (120) @(negedge clk);
    chk("R5", "store result mem[15]", mem[15], 8);
    chk("R4", "acc after indirect add and service add", acc_o, 13);
    chk("R8", "pushed return address mem[14]", mem[14], 4);
    chk("R3", "indirect phase entries", ind_entries, 2);
    chk("R6", "fetches of skipped address 7", fetch7, 0);
    chk("R7", "int_en after service and disable", int_en, 0);
    chk("R9", "halted in execute", phase_o, 4);
    repeat (10) begin
      @(negedge clk);
      chk("R9", "no strobe while halted", {mem_rd, mem_wr}, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule